// File: doc/BRIEF.md
# Vectored Interrupt Router Controller

The controller collects a wide set of edge-signalled interrupt vectors (256 by default, 128 in the reduced build) and keeps each one in a pending bit. A pending bit stays set until software clears it. Each vector has an enable bit. Each vector also has a route byte, which holds a bitmap of target cores in its low nibble and a node number in its high nibble. Vectors are arranged in groups of 32, and each group maps to one output interrupt line through a one-hot line byte. The outputs are level requests, one for each core and line pair.

All state is reached through a 32-bit word-addressed register bus. The bus has separate write and read strobes, and read data arrives one cycle after the read strobe. Software services an interrupt by reading a pending word and writing the same value back to clear it. To move a vector to another core, software disables the vector, rewrites its route byte and then enables it again. Vectors whose node number is not zero are kept but are never delivered locally. The bounce-enable and node-map words are stored for software and have no effect on delivery.

Top module: `vir_ctrl`

## Requirements
- R1: After reset every enable, bounce, pending, route, line-map and node-map bit is 0. Every register reads 0 and `req_o` is all zero.
- R2: A 0-to-1 transition on `irq_i[v]` sets pending bit v at the next clock edge. A level held high does not set the bit again after it is cleared. Pending word k sits at region 2, index k, and holds vector v at index v/32, bit v%32. Even indices are the low halves of the 64-bit status words and odd indices are the high halves.
- R3: A write to a pending word clears each bit that is written as 1 and leaves each bit written as 0 unchanged. If a clear and a rising edge reach the same bit in the same cycle, the bit stays set.
- R4: Enable bits sit at region 0, index v/32, bit v%32. A pending vector that is disabled drives no request and stays pending.
- R5: Route bytes sit at region 3, index v/4, bits 8*(v%4)+7..8*(v%4). Bit c of the low nibble routes the vector to core c, and several set bits route it to several cores.
- R6: A vector whose route byte has a non-zero high nibble (node field) drives no request.
- R7: The line byte of group g = v/32 sits at region 4, index g/4, bits 8*(g%4)+7..8*(g%4). Bit l of that byte sends the group's deliveries for core c to `req_o[c*8+l]`.
- R8: A route write takes effect and reads back whatever the enable state is. Re-enabling a vector delivers it to its new target.
- R9: Bounce words (region 1, index v/32) and node-map words (region 5, same indexing) can be written and read back, and they do not change `req_o`.
- R10: `rdata_o` takes the addressed word one cycle after `rd_i` and holds it while `rd_i` is low. An unused region or an out-of-range index reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_VEC | Edge-style interrupt vector inputs |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Word address: bits [9:7] select the region, bits [6:0] the index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| req_o | output | NUM_CORES*NUM_LINES | Level requests, bit c*NUM_LINES+l is core c on line l |

## Verification
Directed sequences push a single vector through each gate on its own. They change enable, node field, core bitmap and line byte one at a time, so a fault in any one of them appears as a wrong request bit and not as a generic mismatch. Clear patterns written as zeros, written as ones, and written in the same cycle as a new edge separate a W1C register from a write-through or overwrite register. A held-high input shows the difference between edge sensing and level sensing. Random traffic then toggles inputs and rewrites enable, route, line and pending words across all groups, which exposes wrong word or byte indexing that a single-vector test cannot see.

// File: rtl/vir_pkg.sv
package vir_pkg;
  typedef enum logic [2:0] {
    RG_EN     = 3'd0,
    RG_BOUNCE = 3'd1,
    RG_PEND   = 3'd2,
    RG_ROUTE  = 3'd3,
    RG_LINE   = 3'd4,
    RG_NODE   = 3'd5
  } region_e;
endpackage

// File: rtl/vir_pending.sv
module vir_pending #(
  parameter int NUM_VEC = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] irq_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0] irq_q, pend_q, rise;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= (pend_q & ~clr_i) | rise; // set wins over clear
    end
  end

  assign pend_o = pend_q;

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_i)) & ~pend_q) == '0)); // R3

  AST_EDGE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> (($past(rise) & ~pend_q) == '0)); // R2
endmodule

// File: rtl/vir_regs.sv
module vir_regs
  import vir_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int ADDR_W  = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  input  logic [NUM_VEC-1:0]   pend_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_VEC-1:0]   en_o,
  output logic [NUM_VEC*8-1:0] route_o,
  output logic [NUM_VEC/4-1:0] line_o,
  output logic [NUM_VEC-1:0]   pend_clr_o
);
  localparam int NW    = NUM_VEC / 32;
  localparam int NRW   = NUM_VEC / 4;
  localparam int NLW   = NW / 4;
  localparam int IDX_W = ADDR_W - 3;

  region_e            region;
  logic [IDX_W-1:0]   idx;
  logic [31:0]        en_q  [NW];
  logic [31:0]        bn_q  [NW];
  logic [31:0]        nm_q  [NW];
  logic [31:0]        rt_q  [NRW];
  logic [31:0]        ln_q  [NLW];
  logic [31:0]        rd_val, rdata_q;

  assign region = region_e'(addr_i[ADDR_W-1 -: 3]);
  assign idx    = addr_i[IDX_W-1:0];

  for (genvar i = 0; i < NW; i++) begin : g_vec_words
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[i] <= '0;
        bn_q[i] <= '0;
        nm_q[i] <= '0;
      end else if (wr_i && idx == IDX_W'(i)) begin
        if (region == RG_EN)     en_q[i] <= wdata_i;
        if (region == RG_BOUNCE) bn_q[i] <= wdata_i;
        if (region == RG_NODE)   nm_q[i] <= wdata_i;
      end
    end
    assign en_o[i*32 +: 32]       = en_q[i];
    assign pend_clr_o[i*32 +: 32] = (wr_i && region == RG_PEND && idx == IDX_W'(i))
                                    ? wdata_i : 32'h0;
  end

  for (genvar i = 0; i < NRW; i++) begin : g_route_words
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                           rt_q[i] <= '0;
      else if (wr_i && region == RG_ROUTE && idx == IDX_W'(i)) rt_q[i] <= wdata_i;
    end
    assign route_o[i*32 +: 32] = rt_q[i];
  end

  for (genvar i = 0; i < NLW; i++) begin : g_line_words
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          ln_q[i] <= '0;
      else if (wr_i && region == RG_LINE && idx == IDX_W'(i)) ln_q[i] <= wdata_i;
    end
    assign line_o[i*32 +: 32] = ln_q[i];
  end

  always_comb begin
    rd_val = '0;
    unique case (region)
      RG_EN:     for (int i = 0; i < NW;  i++) if (idx == IDX_W'(i)) rd_val = en_q[i];
      RG_BOUNCE: for (int i = 0; i < NW;  i++) if (idx == IDX_W'(i)) rd_val = bn_q[i];
      RG_NODE:   for (int i = 0; i < NW;  i++) if (idx == IDX_W'(i)) rd_val = nm_q[i];
      RG_PEND:   for (int i = 0; i < NW;  i++) if (idx == IDX_W'(i)) rd_val = pend_i[i*32 +: 32];
      RG_ROUTE:  for (int i = 0; i < NRW; i++) if (idx == IDX_W'(i)) rd_val = rt_q[i];
      RG_LINE:   for (int i = 0; i < NLW; i++) if (idx == IDX_W'(i)) rd_val = ln_q[i];
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o)); // R10

  AST_EN_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && region != RG_EN) |=> $stable(en_o)); // R8

  AST_ROUTE_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && region != RG_ROUTE) |=> $stable(route_o)); // R9
endmodule

// File: rtl/vir_deliver.sv
module vir_deliver #(
  parameter int NUM_VEC   = 256,
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_VEC-1:0]             pend_i,
  input  logic [NUM_VEC-1:0]             en_i,
  input  logic [NUM_VEC*8-1:0]           route_i,
  input  logic [NUM_VEC/4-1:0]           line_i,
  output logic [NUM_CORES*NUM_LINES-1:0] req_o
);
  localparam int NG = NUM_VEC / 32;

  logic [NUM_CORES-1:0] grp_hit [NG];

  always_comb begin
    for (int g = 0; g < NG; g++) begin
      grp_hit[g] = '0;
      for (int k = 0; k < 32; k++) begin
        if (pend_i[g*32+k] && en_i[g*32+k] && route_i[(g*32+k)*8+4 +: 4] == 4'h0)
          grp_hit[g] = grp_hit[g] | route_i[(g*32+k)*8 +: NUM_CORES];
      end
    end
  end

  always_comb begin
    req_o = '0;
    for (int g = 0; g < NG; g++)
      for (int c = 0; c < NUM_CORES; c++)
        for (int l = 0; l < NUM_LINES; l++)
          if (grp_hit[g][c] && line_i[g*8+l]) req_o[c*NUM_LINES+l] = 1'b1;
  end

  AST_OFF_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (req_o == '0)); // R4

  AST_NO_LINE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i == '0) |-> (req_o == '0)); // R7

  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i == '0) |-> (req_o == '0)); // R2
endmodule

// File: rtl/vir_ctrl.sv
module vir_ctrl #(
  parameter int NUM_VEC   = 256,
  parameter int NUM_CORES = 4,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 10
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_VEC-1:0]             irq_i,
  input  logic                           wr_i,
  input  logic                           rd_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [31:0]                    wdata_i,
  output logic [31:0]                    rdata_o,
  output logic [NUM_CORES*NUM_LINES-1:0] req_o
);
  logic [NUM_VEC-1:0]   pend, pend_clr, en;
  logic [NUM_VEC*8-1:0] route;
  logic [NUM_VEC/4-1:0] line;

  vir_pending #(.NUM_VEC(NUM_VEC)) u_pending (
    .clk_i, .rst_ni, .irq_i, .clr_i(pend_clr), .pend_o(pend)
  );

  vir_regs #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .pend_i(pend), .rdata_o, .en_o(en), .route_o(route),
    .line_o(line), .pend_clr_o(pend_clr)
  );

  vir_deliver #(.NUM_VEC(NUM_VEC), .NUM_CORES(NUM_CORES), .NUM_LINES(NUM_LINES)) u_deliver (
    .clk_i, .rst_ni, .pend_i(pend), .en_i(en), .route_i(route),
    .line_i(line), .req_o
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (req_o == '0)); // R1
endmodule

// File: tb/vir_ctrl_bench.sv
module vir_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV  = 256;
  localparam int NC  = 4;
  localparam int NL  = 8;
  localparam int NW  = NV / 32;
  localparam int NRW = NV / 4;
  localparam int NLW = NW / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] irq = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [31:0]   req;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_en [NW], m_bn [NW], m_nm [NW], m_pd [NW];
  logic [31:0] m_rt [NRW];
  logic [31:0] m_ln [NLW];
  logic [NV-1:0] m_irq_prev = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vir_ctrl u_vir_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .req_o(req)
  );

  function automatic logic [31:0] model_read(input logic [2:0] rg, input int ix);
    logic [31:0] v;
    v = '0;
    case (rg)
      3'd0: if (ix < NW)  v = m_en[ix];
      3'd1: if (ix < NW)  v = m_bn[ix];
      3'd2: if (ix < NW)  v = m_pd[ix];
      3'd3: if (ix < NRW) v = m_rt[ix];
      3'd4: if (ix < NLW) v = m_ln[ix];
      3'd5: if (ix < NW)  v = m_nm[ix];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] model_req();
    logic [31:0] r;
    r = '0;
    for (int v = 0; v < NV; v++) begin
      logic [7:0] rb, lb;
      rb = m_rt[v/4][8*(v%4) +: 8];
      lb = m_ln[(v/32)/4][8*((v/32)%4) +: 8];
      if (m_pd[v/32][v%32] && m_en[v/32][v%32] && rb[7:4] == 4'h0)
        for (int c = 0; c < NC; c++)
          for (int l = 0; l < NL; l++)
            if (rb[c] && lb[l]) r[c*NL+l] = 1'b1;
    end
    return r;
  endfunction

  task automatic tick();
    logic [NV-1:0] rise;
    int ix;
    @(posedge clk);
    #1;
    rise = irq & ~m_irq_prev;
    m_irq_prev = irq;
    ix = int'(addr[6:0]);
    if (wr) begin
      case (addr[9:7])
        3'd0: if (ix < NW)  m_en[ix] = wdata;
        3'd1: if (ix < NW)  m_bn[ix] = wdata;
        3'd2: if (ix < NW)  m_pd[ix] = m_pd[ix] & ~wdata;
        3'd3: if (ix < NRW) m_rt[ix] = wdata;
        3'd4: if (ix < NLW) m_ln[ix] = wdata;
        3'd5: if (ix < NW)  m_nm[ix] = wdata;
        default: ;
      endcase
    end
    for (int w = 0; w < NW; w++) m_pd[w] = m_pd[w] | rise[w*32 +: 32];
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] rg, input int ix, input logic [31:0] d);
    wr = 1'b1; addr = {rg, 7'(ix)}; wdata = d;
    tick();
    wr = 1'b0;
  endtask

  task automatic reg_read(input string tag, input logic [2:0] rg, input int ix);
    logic [31:0] exp;
    exp = model_read(rg, ix);
    rd = 1'b1; addr = {rg, 7'(ix)};
    tick();
    rd = 1'b0;
    check(tag, rdata, exp);
  endtask

  task automatic check_req(input string tag);
    check(tag, req, model_req());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd1234));
    for (int i = 0; i < NW; i++) begin m_en[i] = '0; m_bn[i] = '0; m_nm[i] = '0; m_pd[i] = '0; end
    for (int i = 0; i < NRW; i++) m_rt[i] = '0;
    for (int i = 0; i < NLW; i++) m_ln[i] = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1: reset state
    check("R1 req after reset", req, 32'h0);
    reg_read("R1 enable word", 3'd0, 0);
    reg_read("R1 route word", 3'd3, 5);
    reg_read("R1 pending word", 3'd2, 7);
    check("R1 pending reads zero", rdata, 32'h0);

    // single vector 3 -> core1, group0 -> line0
    reg_write(3'd4, 0, 32'h0000_0001);
    reg_write(3'd3, 0, 32'h0200_0000);
    reg_write(3'd0, 0, 32'h0000_0008);
    check("R4 enabled but not pending", req, 32'h0);
    irq[3] = 1'b1;
    tick();
    check("R5 core1 line0 request", req, 32'h0000_0100);
    check_req("R7 line map model");
    reg_read("R2 pending bit 3", 3'd2, 0);
    check("R2 pending word value", rdata, 32'h0000_0008);

    // R4: disable keeps pending, drops request
    reg_write(3'd0, 0, 32'h0);
    check("R4 disabled no request", req, 32'h0);
    reg_read("R4 still pending", 3'd2, 0);

    // R8: reroute while disabled to core2, readback, re-enable
    reg_write(3'd3, 0, 32'h0400_0000);
    reg_read("R8 route readback", 3'd3, 0);
    reg_write(3'd0, 0, 32'h0000_0008);
    check("R8 new target core2", req, 32'h0001_0000);

    // R5: multi-core bitmap, R7: line 5
    reg_write(3'd3, 0, 32'h0900_0000);
    reg_write(3'd4, 0, 32'h0000_0020);
    check("R5 cores 0 and 3 on line5", req, 32'h2000_0020);

    // R6: node field nonzero
    reg_write(3'd3, 0, 32'h1900_0000);
    check("R6 remote node no request", req, 32'h0);
    reg_write(3'd3, 0, 32'h0900_0000);

    // R3: W1C with zeros keeps, with ones clears
    reg_write(3'd2, 0, 32'h0000_0000);
    reg_read("R3 zero write keeps", 3'd2, 0);
    reg_write(3'd2, 0, 32'h0000_0008);
    reg_read("R3 one write clears", 3'd2, 0);
    check("R3 cleared value", rdata, 32'h0);
    // R2: level held high does not re-set
    tick();
    reg_read("R2 no retrigger on level", 3'd2, 0);
    check("R2 held level request", req, 32'h0);
    // R3: clear and new edge same cycle
    irq[3] = 1'b0;
    tick();
    irq[3] = 1'b1;
    reg_write(3'd2, 0, 32'h0000_0008);
    reg_read("R3 edge wins over clear", 3'd2, 0);
    check("R3 bit still set", rdata, 32'h0000_0008);

    // R9: bounce and node map stored, no effect on requests
    held = req;
    reg_write(3'd1, 2, 32'hA5A5_0F0F);
    reg_write(3'd5, 1, 32'h0008_0004);
    reg_read("R9 bounce readback", 3'd1, 2);
    reg_read("R9 node map readback", 3'd5, 1);
    check("R9 request unchanged", req, held);

    // R10: unmapped read, hold after strobe, ignored write
    reg_write(3'd7, 0, 32'hFFFF_FFFF);
    reg_write(3'd0, 20, 32'hFFFF_FFFF);
    reg_read("R10 unmapped region", 3'd7, 0);
    reg_read("R10 out of range index", 3'd0, 20);
    reg_read("R10 valid read", 3'd1, 2);
    tick(); tick();
    check("R10 rdata held", rdata, 32'hA5A5_0F0F);

    // random traffic
    for (int it = 0; it < 600; it++) begin
      int op, ix;
      logic [31:0] d;
      op = int'($urandom % 8);
      case (op)
        0, 1: begin
          for (int b = 0; b < 4; b++) irq[$urandom % NV] ^= 1'b1;
          tick();
        end
        2: reg_write(3'd0, int'($urandom % NW), $urandom);
        3: begin
          d = '0;
          for (int b = 0; b < 4; b++) begin
            d[8*b +: 4] = 4'($urandom);
            d[8*b+4 +: 4] = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
          end
          reg_write(3'd3, int'($urandom % NRW), d);
        end
        4: begin
          d = '0;
          for (int b = 0; b < 4; b++) d[8*b + int'($urandom % 8)] = 1'b1;
          reg_write(3'd4, int'($urandom % NLW), d);
        end
        5: reg_write(3'd2, int'($urandom % NW), $urandom);
        6: reg_read("R2 random pending read", 3'd2, int'($urandom % NW));
        default: begin
          ix = int'($urandom % 6);
          reg_read("R10 random read", 3'(ix), int'($urandom % 8));
        end
      endcase
      check_req("R7 random request map");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule